// File: doc/BRIEF.md
# Two-wire serial EEPROM slave engine

This block is the slave half of a two-wire serial memory. It works on SCL and SDA samples that are already synchronised to the system clock. It pulls SDA low through an open-drain output enable. It finds START and STOP conditions and checks the device-select byte against its strap pins. It receives a word address and data bytes, and it sends stored bytes back to the master one bit at a time. A small synchronous RAM holds the array.

Writes are not applied byte by byte. Received data bytes collect in a page-sized holding buffer. The STOP that closes the write sequence starts a busy period, counted in system clocks, and the buffer is copied into the array during that period. While the busy period runs, the slave acknowledges nothing, so a master can find out when the write has finished by repeatedly sending the device-select byte (acknowledge polling). A write-protect input turns a write sequence into one that is acknowledged but never stored.

The word-address width sets the density, from 8 to 11 bits. Every strap bit that is not needed to select the device becomes an upper word-address bit carried in the device-select byte. With the default of 9 bits, the slave compares select bits [3:2] against strap pins [2:1], and select bit 1 carries word-address bit 8.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) clears the bit counter and begins reception of a device-select byte from any state, including partway through a byte. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: The slave changes its SDA drive only while SCL is low, in response to a sampled SCL falling edge. Read data goes out MSB first.
- R3: A device-select byte is accepted only if bits [7:4] equal 1010 and the compared select bits equal the strap pins. The default compares bits [3:2] with pins [2:1]. Bit 0 selects the direction: 1 means read, 0 means write. On a mismatch the slave does not acknowledge and ignores the bus until the next START.
- R4: For every byte it accepts (device select, word address, data), the slave holds SDA low for the ninth clock and releases it after the ninth SCL falling edge.
- R5: Data bytes that follow the word address are stored at successive offsets. Only the low PAGE_W address bits advance, and they wrap to the start of the same page. Nothing reaches the array before the STOP.
- R6: A STOP that ends a write sequence holding at least one data byte, with write protect low, starts a busy period of BUSY_CYCLES clocks. No device-select byte is acknowledged until the period ends, and after it ends device-select bytes are acknowledged again.
- R7: When write protect is high at the STOP, the data bytes have still been acknowledged, but the array is unchanged and no busy period starts.
- R8: A read-direction device-select byte replaces the upper word-address bits with its page bits and keeps the low 8 bits of the internal pointer. It then returns the byte at that address, so a current-address read yields the byte after the last one accessed.
- R9: A write-direction device-select byte followed only by a word address, then a repeated START with the read bit set, returns the byte at that address and starts no busy period.
- R10: A master acknowledge (0) on the ninth clock of a read byte sends the next address, and the pointer wraps from the last location of the array to 0. A no-acknowledge (1) ends the read with SDA released.
- R11: A START that arrives before the STOP of a write sequence discards the buffered data bytes, so no commit and no busy period follow.
- R12: After reset the slave is idle, SDA is released and no busy period is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock sample |
| sda_i | input | 1 | Synchronised serial data sample (wired-AND bus level) |
| wp_i | input | 1 | Write protect; high blocks array updates |
| dev_sel_i | input | 3 | Strap pins compared against the device-select byte |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench targets these corner cases:
- Page wrap. Four bytes are written starting two below a page boundary. A design that carried into the upper address bits would put the last two bytes in the next page, and the later random read of the page start would return the wrong value.
- Page bits replacing the pointer's upper bits. After a read that leaves the pointer in the upper half, a current-address read names the lower half. A design that kept the old upper bits would return the byte from the wrong page.
- Sequential read from the last location. A design that wrapped within a page, or stopped at the end, would not return location 0.
- Write protect. The bench polls immediately after a protected write; if the design ran a busy period anyway, that poll would get no acknowledge.
- Aborted transfers. A START partway through a byte, and a repeated START before the STOP of a write, are both sent. A design that failed to clear its bit counter would lose framing, and one that kept the buffer would commit stale bytes.

// File: rtl/tw_eeprom_pkg.sv
// Shared types for the two-wire EEPROM slave engine.
package tw_eeprom_pkg;

    // Bus-side protocol states of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until a START
        ST_RX,     // shifting in a byte on SCL rising edges
        ST_ACKW,   // byte accepted, waiting for SCL to fall before acking
        ST_ACK,    // holding SDA low for the ninth clock
        ST_TX,     // shifting a byte out on SCL falling edges
        ST_MACK    // released SDA, sampling the master's acknowledge
    } tw_state_e;

    // What the byte being received will be used for.
    typedef enum logic [1:0] {
        RX_DEV,
        RX_WADDR,
        RX_DATA
    } tw_rx_kind_e;

    // Fixed device-type nibble at the top of the device-select byte.
    localparam logic [3:0] TW_DEV_TYPE = 4'b1010;

endpackage

// File: rtl/tw_bus_cond.sv
// Bus condition detector.
// Registers the previous SCL/SDA samples and flags START, STOP and the SCL
// edges for one system clock each. Assumes both inputs are already
// synchronised to clk and glitch-free.
module tw_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_q;
    logic sda_q;

    // Keep one cycle of history; an idle bus reads as high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA edges while SCL stays high are conditions; SCL edges clock data.
    always_comb begin
        start_o    = scl_q & scl_i & sda_q & ~sda_i;
        stop_o     = scl_q & scl_i & ~sda_q & sda_i;
        scl_rise_o = ~scl_q & scl_i;
        scl_fall_o = scl_q & ~scl_i;
    end

endmodule

// File: rtl/tw_page_buf.sv
// Page holding buffer.
// One byte plus a valid bit per page offset. A later write to the same offset
// replaces the earlier byte. Clearing drops every valid bit. The read port is
// combinational and is used by the commit walk.
module tw_page_buf #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_idx_i,
    input  logic [7:0]        wr_data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    output logic              any_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            ent_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] ent_vld;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
        // Capture the byte aimed at this offset; clear has priority.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                ent_vld[g]  <= 1'b0;
                ent_data[g] <= 8'h00;
            end else if (wr_i && wr_idx_i == PAGE_W'(g)) begin
                ent_vld[g]  <= 1'b1;
                ent_data[g] <= wr_data_i;
            end
        end
    end

    // Expose the selected entry and whether anything is pending.
    always_comb begin
        rd_data_o  = ent_data[rd_idx_i];
        rd_valid_o = ent_vld[rd_idx_i];
        any_o      = |ent_vld;
    end

endmodule

// File: rtl/tw_ram.sv
// Storage array: simple dual-port synchronous RAM with one write port and a
// registered read port (one clock of read latency). Contents are not reset.
module tw_ram #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Write on request, read every cycle.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/tw_eeprom_slave.sv
// Two-wire serial EEPROM slave engine (top).
// Decodes the device-select byte, word address and data bytes, acks each
// accepted byte, and streams read data MSB first. Write data is buffered per
// page and committed during a busy period that starts at STOP; while busy,
// no device select is acknowledged. Assumes scl_i/sda_i are synchronised,
// 8 <= ADDR_W <= 11, and BUSY_CYCLES > 2**PAGE_W so the commit walk fits.
module tw_eeprom_slave #(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_oe_o
);

    import tw_eeprom_pkg::*;

    localparam int          PAGE_BYTES = 1 << PAGE_W;
    localparam int          PBITS      = ADDR_W - 8;
    localparam logic [2:0]  CMP_MASK   = 3'(7 << PBITS);
    localparam int          BUSY_W     = $clog2(BUSY_CYCLES + 1);
    localparam int          ROW_W      = ADDR_W - PAGE_W;

    // Bus conditions
    logic start_det, stop_det, scl_rise, scl_fall;

    // Protocol state
    tw_state_e    state;
    tw_rx_kind_e  rx_kind;
    logic [2:0]   bit_cnt;
    logic [6:0]   shreg;
    logic [7:0]   tx_sh;
    logic [2:0]   dev_hi;
    logic         go_tx;
    logic [ADDR_W-1:0] ptr;

    // Busy / commit
    logic              busy;
    logic [BUSY_W-1:0] busy_cnt;
    logic              commit_run;
    logic [PAGE_W-1:0] commit_idx;
    logic [ROW_W-1:0]  commit_row;

    // Datapath
    logic [7:0] byte_in;
    logic       byte_done;
    logic       dev_match;
    logic       buf_wr, buf_clr, buf_any, buf_vld;
    logic [7:0] buf_data;
    logic       mem_we;
    logic [7:0] rd_data;
    logic       busy_go, busy_last;

    tw_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    // Byte assembly and device-select decode.
    always_comb begin
        byte_in   = {shreg, sda_i};
        byte_done = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7)
                    && !start_det && !stop_det;
        dev_match = (byte_in[7:4] == TW_DEV_TYPE)
                    && (((byte_in[3:1] ^ dev_sel_i) & CMP_MASK) == 3'b000)
                    && !busy;
        buf_wr    = byte_done && (rx_kind == RX_DATA);
    end

    // Busy start/end and buffer clearing rules.
    always_comb begin
        busy_go   = stop_det && !busy && buf_any && !wp_i;
        busy_last = busy && (busy_cnt == BUSY_W'(1));
        buf_clr   = (start_det && !busy)
                    || (stop_det && !busy && !busy_go)
                    || busy_last;
        mem_we    = commit_run && buf_vld;
    end

    tw_page_buf #(
        .PAGE_W (PAGE_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (buf_clr),
        .wr_i       (buf_wr),
        .wr_idx_i   (ptr[PAGE_W-1:0]),
        .wr_data_i  (byte_in),
        .rd_idx_i   (commit_idx),
        .rd_data_o  (buf_data),
        .rd_valid_o (buf_vld),
        .any_o      (buf_any)
    );

    tw_ram #(
        .AW (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i ({commit_row, commit_idx}),
        .wdata_i (buf_data),
        .raddr_i (ptr),
        .rdata_o (rd_data)
    );

    // Protocol FSM: receive, acknowledge, transmit, master-ack handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rx_kind  <= RX_DEV;
            bit_cnt  <= 3'd0;
            shreg    <= 7'd0;
            tx_sh    <= 8'd0;
            dev_hi   <= 3'd0;
            go_tx    <= 1'b0;
            ptr      <= '0;
            sda_oe_o <= 1'b0;
        end else if (start_det) begin
            state    <= ST_RX;
            rx_kind  <= RX_DEV;
            bit_cnt  <= 3'd0;
            sda_oe_o <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= 3'd0;
            sda_oe_o <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg   <= byte_in[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            case (rx_kind)
                                RX_DEV: begin
                                    if (dev_match) begin
                                        dev_hi <= byte_in[3:1];
                                        go_tx  <= byte_in[0];
                                        state  <= ST_ACKW;
                                        if (byte_in[0]) begin
                                            ptr <= ADDR_W'({byte_in[3:1], ptr[7:0]});
                                        end else begin
                                            rx_kind <= RX_WADDR;
                                        end
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_WADDR: begin
                                    ptr     <= ADDR_W'({dev_hi, byte_in});
                                    rx_kind <= RX_DATA;
                                    state   <= ST_ACKW;
                                end
                                default: begin
                                    ptr   <= {ptr[ADDR_W-1:PAGE_W],
                                              ptr[PAGE_W-1:0] + PAGE_W'(1)};
                                    state <= ST_ACKW;
                                end
                            endcase
                        end
                    end
                end
                ST_ACKW: begin
                    if (scl_fall) begin
                        sda_oe_o <= 1'b1;
                        state    <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= 3'd0;
                        if (go_tx) begin
                            sda_oe_o <= ~rd_data[7];
                            tx_sh    <= {rd_data[6:0], 1'b0};
                            ptr      <= ptr + ADDR_W'(1);
                            state    <= ST_TX;
                        end else begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_MACK;
                        end else begin
                            sda_oe_o <= ~tx_sh[7];
                            tx_sh    <= {tx_sh[6:0], 1'b0};
                            bit_cnt  <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && sda_i) begin
                        state <= ST_IDLE;
                    end else if (scl_fall) begin
                        sda_oe_o <= ~rd_data[7];
                        tx_sh    <= {rd_data[6:0], 1'b0};
                        ptr      <= ptr + ADDR_W'(1);
                        bit_cnt  <= 3'd0;
                        state    <= ST_TX;
                    end
                end
                default: begin
                    sda_oe_o <= 1'b0;
                end
            endcase
        end
    end

    // Busy timer and commit walk over the page buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            busy_cnt   <= '0;
            commit_run <= 1'b0;
            commit_idx <= '0;
            commit_row <= '0;
        end else if (busy_go) begin
            busy       <= 1'b1;
            busy_cnt   <= BUSY_W'(BUSY_CYCLES);
            commit_run <= 1'b1;
            commit_idx <= '0;
            commit_row <= ptr[ADDR_W-1:PAGE_W];
        end else if (busy) begin
            busy_cnt <= busy_cnt - BUSY_W'(1);
            if (busy_last) begin
                busy <= 1'b0;
            end
            if (commit_run) begin
                commit_idx <= commit_idx + PAGE_W'(1);
                if (commit_idx == PAGE_W'(PAGE_BYTES - 1)) begin
                    commit_run <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tw_eeprom_chk.sv
// Protocol checker for tw_eeprom_slave, attached by bind below.
// Observes bus conditions, the SDA enable, the busy flag and the commit port.
module tw_eeprom_chk (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     scl_i,
    input logic                     wp_i,
    input logic                     sda_oe,
    input logic                     busy,
    input logic                     mem_we,
    input logic                     start,
    input logic                     stop,
    input tw_eeprom_pkg::tw_state_e state,
    input logic [2:0]               bit_cnt
);

    import tw_eeprom_pkg::*;

    // R2: the slave only starts pulling SDA low while SCL is low.
    assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R1: a START restarts reception with a cleared bit counter.
    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_RX && bit_cnt == 3'd0 && !sda_oe));

    // R1: a STOP parks the slave with SDA released.
    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state == ST_IDLE && !sda_oe));

    // R6: silent on the bus for the whole busy period.
    assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5: the array is only written during a busy period.
    assert_commit_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7: a busy period never starts while write protect was high.
    assert_wp_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

endmodule

bind tw_eeprom_slave tw_eeprom_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .wp_i    (wp_i),
    .sda_oe  (sda_oe_o),
    .busy    (busy),
    .mem_we  (mem_we),
    .start   (start_det),
    .stop    (stop_det),
    .state   (state),
    .bit_cnt (bit_cnt)
);

// File: tb/tb_tw_eeprom_slave.sv
// Bench for tw_eeprom_slave: a bit-level master model, a table of byte
// writes checked by random reads, then directed corner cases.
module tb_tw_eeprom_slave;

    localparam int         H    = 6;          // SCL half period in clocks
    localparam logic [2:0] PINS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tw_eeprom_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .wp_i      (wp),
        .dev_sel_i (PINS),
        .sda_oe_o  (sda_oe)
    );

    // Table entries: {word address, data}
    localparam logic [16:0] VEC [5] = '{
        {9'h000, 8'h3C},
        {9'h1FF, 8'hC3},
        {9'h0A3, 8'h96},
        {9'h150, 8'h42},
        {9'h02F, 8'h5A}
    };

    function automatic logic [7:0] dv(input logic [8:0] a, input logic rd);
        return {4'b1010, PINS[2:1], a[8], rd};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; hp();
        scl = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl = 1'b0; hp();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hp();
        scl = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp();
            scl = 1'b1; hp();
            scl = 1'b0;
        end
        sda_m = 1'b1; hp();
        scl = 1'b1;
        repeat (H / 2) @(negedge clk);
        ack = sda_line;
        repeat (H - H / 2) @(negedge clk);
        scl = 1'b0;
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp();
            scl = 1'b1;
            repeat (H / 2) @(negedge clk);
            b[i] = sda_line;
            repeat (H - H / 2) @(negedge clk);
            scl = 1'b0;
        end
        @(negedge clk);
        sda_m = mack; hp();
        scl = 1'b1; hp();
        scl = 1'b0;
        @(negedge clk);
        sda_m = 1'b1;
    endtask

    // Poll with a write-direction select until acknowledged; n = attempts.
    task automatic poll(output int n);
        logic ack;
        n = 0;
        do begin
            m_start();
            m_wbyte(dv(9'h000, 1'b0), ack);
            m_stop();
            n++;
        end while (ack && n < 40);
        chk("R6 poll ends acked", {7'd0, ack}, 8'h00);
    endtask

    task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
        logic ack;
        m_start();
        m_wbyte(dv(a, 1'b0), ack);
        m_wbyte(a[7:0], ack);
        m_start();
        m_wbyte(dv(a, 1'b1), ack);
        chk("R9 read select acked", {7'd0, ack}, 8'h00);
        m_rbyte(1'b1, d);
        m_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         n;

        repeat (5) @(negedge clk);
        // R12: released and not busy out of reset
        chk("R12 sda released", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 sda released", {7'd0, sda_oe}, 8'h00);
        poll(n);
        chk("R12 no busy after reset", 8'(n), 8'd1);

        // Table: byte write, busy poll, random read back
        foreach (VEC[k]) begin
            logic [8:0] a;
            logic [7:0] v;
            a = VEC[k][16:8];
            v = VEC[k][7:0];
            m_start();
            m_wbyte(dv(a, 1'b0), ack); chk("R4 select ack", {7'd0, ack}, 8'h00);
            m_wbyte(a[7:0], ack);      chk("R4 address ack", {7'd0, ack}, 8'h00);
            m_wbyte(v, ack);           chk("R4 data ack", {7'd0, ack}, 8'h00);
            m_stop();
            poll(n);
            chk("R6 busy nacks first poll", 8'(n > 1), 8'd1);
            rand_read(a, d);
            chk("R9 R2 random read data", d, v);
        end

        // R3: strap mismatch and wrong type nibble are not acknowledged
        m_start();
        m_wbyte({4'b1010, 2'b01, 1'b0, 1'b0}, ack);
        chk("R3 strap mismatch nack", {7'd0, ack}, 8'h01);
        m_stop();
        m_start();
        m_wbyte({4'b1011, PINS[2:1], 1'b0, 1'b0}, ack);
        chk("R3 type mismatch nack", {7'd0, ack}, 8'h01);
        m_stop();

        // R5: page write wrapping within page 0x120..0x12F
        m_start();
        m_wbyte(dv(9'h12E, 1'b0), ack);
        m_wbyte(8'h2E, ack);
        m_wbyte(8'h11, ack);
        m_wbyte(8'h22, ack);
        m_wbyte(8'h33, ack);
        m_wbyte(8'h44, ack); chk("R5 page data ack", {7'd0, ack}, 8'h00);
        m_stop();
        poll(n);
        chk("R6 busy after page write", 8'(n > 1), 8'd1);
        rand_read(9'h120, d); chk("R5 wrapped byte at page start", d, 8'h33);
        rand_read(9'h12F, d); chk("R5 byte at page end", d, 8'h22);

        // R8: current address read keeps low bits, takes page bit from select
        rand_read(9'h120, d);
        m_start();
        m_wbyte(dv(9'h100, 1'b1), ack);
        m_rbyte(1'b1, d); m_stop();
        chk("R8 current read next byte", d, 8'h44);
        rand_read(9'h12E, d);
        m_start();
        m_wbyte(dv(9'h000, 1'b1), ack);
        m_rbyte(1'b1, d); m_stop();
        chk("R8 page bit replaces upper pointer", d, 8'h5A);

        // R10: sequential read wraps from last location to 0
        m_start();
        m_wbyte(dv(9'h1FF, 1'b0), ack);
        m_wbyte(8'hFF, ack);
        m_start();
        m_wbyte(dv(9'h1FF, 1'b1), ack);
        m_rbyte(1'b0, d); chk("R10 first sequential byte", d, 8'hC3);
        m_rbyte(1'b1, d); chk("R10 wrapped to location 0", d, 8'h3C);
        chk("R10 sda released after nack", {7'd0, sda_oe}, 8'h00);
        m_stop();

        // R7: write protect acks but neither commits nor goes busy
        wp = 1'b1;
        m_start();
        m_wbyte(dv(9'h0A3, 1'b0), ack);
        m_wbyte(8'hA3, ack);
        m_wbyte(8'hEE, ack); chk("R7 protected data still acked", {7'd0, ack}, 8'h00);
        m_stop();
        poll(n);
        chk("R7 no busy when protected", 8'(n), 8'd1);
        wp = 1'b0;
        rand_read(9'h0A3, d); chk("R7 array unchanged", d, 8'h96);

        // R11: repeated START before STOP drops buffered data
        m_start();
        m_wbyte(dv(9'h150, 1'b0), ack);
        m_wbyte(8'h50, ack);
        m_wbyte(8'h77, ack);
        m_start();
        m_wbyte(dv(9'h150, 1'b0), ack);
        chk("R11 select acked, not busy", {7'd0, ack}, 8'h00);
        m_wbyte(8'h50, ack);
        m_start();
        m_wbyte(dv(9'h150, 1'b1), ack);
        m_rbyte(1'b1, d); m_stop();
        chk("R11 buffered byte discarded", d, 8'h42);
        poll(n);
        chk("R11 R9 no busy after dummy write", 8'(n), 8'd1);

        // R1: START in the middle of a byte resynchronises the slave
        m_start();
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; hp();
            scl = 1'b1; hp();
            scl = 1'b0;
        end
        rand_read(9'h000, d);
        chk("R1 read after mid-byte START", d, 8'h3C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule